// File: doc/BRIEF.md
# Displacement Address Generation Unit

This unit turns one four-byte register-plus-displacement instruction into an effective memory address. It takes the instruction word, a valid strobe and two combinational read ports of a 16-entry, 32-bit general-purpose register file. The second instruction byte names two registers. A select bit in the trailing 16-bit extension word decides which of the two acts as the base pointer. The unit adds a zero-extended 12-bit unsigned offset to that pointer.

Only the eight-opcode group that uses this format is accepted. A foreign opcode, or any set bit in the three must-be-zero extension bits, raises an illegal flag instead of an address. All results are registered and appear one clock after the strobe. They hold their value while no strobe arrives.

Top module: `dagu_top`

## Requirements
- R1: While reset is applied and until the first strobe after it, `out_valid`, `out_illegal`, `out_addr`, `out_ptr_idx` and `out_dat_idx` are all zero.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high, so each strobe yields one result one clock later.
- R3: The opcode is `in_insn[31:24]`. Values 0xd0 to 0xd7 are accepted, and any other value sets `out_illegal`.
- R4: The must-be-zero field is `in_insn[14:12]`. Any nonzero value sets `out_illegal`, even when the opcode is accepted.
- R5: When `out_illegal` is high, `out_addr`, `out_ptr_idx` and `out_dat_idx` are zero.
- R6: The first register code is `in_insn[23:20]` and the second is `in_insn[19:16]`. The select bit is `in_insn[15]`. With the select bit at 0 the first code is the pointer and the second is the data register. With the select bit at 1 the roles swap. The pointer index is reported on `out_ptr_idx` and the data index on `out_dat_idx`.
- R7: For a legal instruction, `out_addr` equals the pointer register value plus `in_insn[11:0]`, zero-extended to 32 bits.
- R8: The addition wraps modulo 2^32.
- R9: In cycles without a strobe, `out_addr`, `out_illegal`, `out_ptr_idx` and `out_dat_idx` keep their last values.
- R10: Read port A is addressed by the first register code and read port B by the second, combinationally in the same cycle as the instruction.
- R11: Both register codes may name the same register, and the address is then formed from that register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Instruction strobe |
| in_insn | input | 32 | Instruction: opcode [31:24], register byte [23:16], extension word [15:0] |
| rf_raddr_a | output | 4 | Register file read port A index (first register code) |
| rf_rdata_a | input | 32 | Register file read port A data |
| rf_raddr_b | output | 4 | Register file read port B index (second register code) |
| rf_rdata_b | input | 32 | Register file read port B data |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_addr | output | 32 | Effective address, zero when illegal |
| out_ptr_idx | output | 4 | Index of the pointer register |
| out_dat_idx | output | 4 | Index of the data register |
| out_illegal | output | 1 | Instruction is outside the group or has reserved bits set |

## Verification
Two faults can fall in the same cycle: a foreign opcode and a nonzero must-be-zero field. The bench sends words that carry both, as well as words that carry only one. It judges each case by a single raised illegal flag with zeroed address and indices. A second coincidence is a legal word whose pointer sits near the top of the address space while the select bit swaps the roles. Here the wrap and the swap must both be right in the same result. Such words are sent back to back, and others are sent between idle gaps, so the result register's hold behaviour is exercised along the way.

// File: rtl/dagu_pkg.sv
package dagu_pkg;
  // Fixed instruction format of the displacement group
  localparam int unsigned INSN_W  = 32;
  localparam int unsigned OPC_W   = 8;
  localparam int unsigned OPC_LSB = 24;
  localparam int unsigned RIDX_W  = 4;
  localparam int unsigned RA_LSB  = 20;
  localparam int unsigned RB_LSB  = 16;
  localparam int unsigned SEL_POS = 15;
  localparam int unsigned RSV_HI  = 14;
  localparam int unsigned RSV_LO  = 12;
  localparam int unsigned DISP_W  = 12;

  typedef struct packed {
    logic [RIDX_W-1:0] ptr_idx;
    logic [RIDX_W-1:0] dat_idx;
    logic              sel_b;
    logic [DISP_W-1:0] disp;
    logic              bad_opc;
    logic              bad_rsv;
  } dagu_fields_t;
endpackage

// File: rtl/dagu_rst_sync.sv
module dagu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/dagu_decode.sv
module dagu_decode
  import dagu_pkg::*;
#(
  parameter logic [OPC_W-1:0] OPC_BASE       = 8'hd0,
  parameter int unsigned      OPC_GROUP_LOG2 = 3
) (
  input  logic [INSN_W-1:0] insn,
  output logic [RIDX_W-1:0] raddr_a,
  output logic [RIDX_W-1:0] raddr_b,
  output dagu_fields_t      fields
);
  localparam int unsigned TAG_W = OPC_W - OPC_GROUP_LOG2;

  logic [OPC_W-1:0]  opc;
  logic [TAG_W-1:0]  opc_tag;
  logic [RIDX_W-1:0] code_a;
  logic [RIDX_W-1:0] code_b;
  logic              sel_b;

  assign opc     = insn[OPC_LSB +: OPC_W];
  assign opc_tag = opc[OPC_W-1:OPC_GROUP_LOG2];
  assign code_a  = insn[RA_LSB +: RIDX_W];
  assign code_b  = insn[RB_LSB +: RIDX_W];
  assign sel_b   = insn[SEL_POS];

  assign raddr_a = code_a;
  assign raddr_b = code_b;

  always_comb begin
    fields.sel_b   = sel_b;
    fields.ptr_idx = sel_b ? code_b : code_a;
    fields.dat_idx = sel_b ? code_a : code_b;
    fields.disp    = insn[DISP_W-1:0];
    fields.bad_opc = (opc_tag != OPC_BASE[OPC_W-1:OPC_GROUP_LOG2]);
    fields.bad_rsv = |insn[RSV_HI:RSV_LO];
  end
endmodule

// File: rtl/dagu_agen.sv
module dagu_agen
  import dagu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              sel_b,
  input  logic [ADDR_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] rdata_b,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] addr
);
  localparam int unsigned PAD_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] offset;

  assign base   = sel_b ? rdata_b : rdata_a;
  assign offset = {{PAD_W{1'b0}}, disp};
  assign addr   = base + offset;  // wraps modulo 2^ADDR_W
endmodule

// File: rtl/dagu_top.sv
module dagu_top
  import dagu_pkg::*;
#(
  parameter int unsigned      ADDR_W         = 32,
  parameter logic [OPC_W-1:0] OPC_BASE       = 8'hd0,
  parameter int unsigned      OPC_GROUP_LOG2 = 3,
  parameter int unsigned      RST_STAGES     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] in_insn,
  output logic [RIDX_W-1:0] rf_raddr_a,
  input  logic [ADDR_W-1:0] rf_rdata_a,
  output logic [RIDX_W-1:0] rf_raddr_b,
  input  logic [ADDR_W-1:0] rf_rdata_b,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [RIDX_W-1:0] out_ptr_idx,
  output logic [RIDX_W-1:0] out_dat_idx,
  output logic              out_illegal
);
  logic              rst_sync_n;
  dagu_fields_t      fields;
  logic [ADDR_W-1:0] sum_addr;

  logic              illegal_d;
  logic [ADDR_W-1:0] addr_d;
  logic [RIDX_W-1:0] ptr_d;
  logic [RIDX_W-1:0] dat_d;

  dagu_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  dagu_decode #(.OPC_BASE(OPC_BASE), .OPC_GROUP_LOG2(OPC_GROUP_LOG2)) u_dec (
    .insn    (in_insn),
    .raddr_a (rf_raddr_a),
    .raddr_b (rf_raddr_b),
    .fields  (fields)
  );

  dagu_agen #(.ADDR_W(ADDR_W)) u_agen (
    .sel_b   (fields.sel_b),
    .rdata_a (rf_rdata_a),
    .rdata_b (rf_rdata_b),
    .disp    (fields.disp),
    .addr    (sum_addr)
  );

  // next-state
  always_comb begin
    illegal_d = fields.bad_opc | fields.bad_rsv;
    if (illegal_d) begin
      addr_d = '0;
      ptr_d  = '0;
      dat_d  = '0;
    end else begin
      addr_d = sum_addr;
      ptr_d  = fields.ptr_idx;
      dat_d  = fields.dat_idx;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_valid <= 1'b0;
    else             out_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_addr    <= '0;
      out_ptr_idx <= '0;
      out_dat_idx <= '0;
      out_illegal <= 1'b0;
    end else if (in_valid) begin
      out_addr    <= addr_d;
      out_ptr_idx <= ptr_d;
      out_dat_idx <= dat_d;
      out_illegal <= illegal_d;
    end
  end
endmodule

// File: rtl/dagu_checker.sv
module dagu_checker
  import dagu_pkg::*;
#(
  parameter int unsigned      ADDR_W         = 32,
  parameter logic [OPC_W-1:0] OPC_BASE       = 8'hd0,
  parameter int unsigned      OPC_GROUP_LOG2 = 3
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              in_valid,
  input logic [INSN_W-1:0] in_insn,
  input logic [RIDX_W-1:0] rf_raddr_a,
  input logic [ADDR_W-1:0] rf_rdata_a,
  input logic [RIDX_W-1:0] rf_raddr_b,
  input logic [ADDR_W-1:0] rf_rdata_b,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic [RIDX_W-1:0] out_ptr_idx,
  input logic [RIDX_W-1:0] out_dat_idx,
  input logic              out_illegal
);
  logic              grp_ok;
  logic              rsv_ok;
  logic [ADDR_W-1:0] ref_sum;
  logic [RIDX_W-1:0] ref_ptr;

  assign grp_ok  = (in_insn[31:24] >= OPC_BASE) &&
                   (in_insn[31:24] <= OPC_BASE + ((1 << OPC_GROUP_LOG2) - 1));
  assign rsv_ok  = (in_insn[14:12] == 3'b000);
  assign ref_ptr = in_insn[15] ? in_insn[19:16] : in_insn[23:20];
  assign ref_sum = (in_insn[15] ? rf_rdata_b : rf_rdata_a) + ADDR_W'(in_insn[11:0]);

  p_strobe_result_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);
  p_foreign_opcode_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !grp_ok) |=> out_illegal);
  p_reserved_set_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !rsv_ok) |=> out_illegal);
  p_illegal_zeroes_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_illegal |-> (out_addr == '0 && out_ptr_idx == '0 && out_dat_idx == '0));
  p_pointer_role_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && grp_ok && rsv_ok) |=> (out_ptr_idx == $past(ref_ptr)));
  p_sum_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && grp_ok && rsv_ok) |=> (!out_illegal && out_addr == $past(ref_sum)));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(out_addr) && $stable(out_illegal) &&
                   $stable(out_ptr_idx) && $stable(out_dat_idx)));
  p_read_ports_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rf_raddr_a == in_insn[23:20] && rf_raddr_b == in_insn[19:16]));
endmodule

bind dagu_top dagu_checker #(
  .ADDR_W(ADDR_W), .OPC_BASE(OPC_BASE), .OPC_GROUP_LOG2(OPC_GROUP_LOG2)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .in_valid(in_valid), .in_insn(in_insn),
  .rf_raddr_a(rf_raddr_a), .rf_rdata_a(rf_rdata_a),
  .rf_raddr_b(rf_raddr_b), .rf_rdata_b(rf_rdata_b),
  .out_valid(out_valid), .out_addr(out_addr), .out_ptr_idx(out_ptr_idx),
  .out_dat_idx(out_dat_idx), .out_illegal(out_illegal)
);

// File: tb/tb_dagu_top.sv
module tb_dagu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_insn = '0;
  logic [3:0]  rf_raddr_a, rf_raddr_b;
  logic [31:0] rf_rdata_a, rf_rdata_b;
  logic        out_valid, out_illegal;
  logic [31:0] out_addr;
  logic [3:0]  out_ptr_idx, out_dat_idx;

  logic [31:0] regs [16];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] addr;
    logic [3:0]  ptr;
    logic [3:0]  dat;
    logic        ill;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;  // 50 MHz

  assign rf_rdata_a = regs[rf_raddr_a];
  assign rf_rdata_b = regs[rf_raddr_b];

  dagu_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
    .rf_raddr_a(rf_raddr_a), .rf_rdata_a(rf_rdata_a),
    .rf_raddr_b(rf_raddr_b), .rf_rdata_b(rf_rdata_b),
    .out_valid(out_valid), .out_addr(out_addr), .out_ptr_idx(out_ptr_idx),
    .out_dat_idx(out_dat_idx), .out_illegal(out_illegal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected result built from the requirements
  function automatic exp_t model(input logic [31:0] w, input string tag);
    exp_t e;
    logic sel;
    e.tag = tag;
    e.ill = (w[31:24] < 8'hd0) || (w[31:24] > 8'hd7) || (w[14:12] != 3'b000);
    sel   = w[15];
    e.ptr = sel ? w[19:16] : w[23:20];
    e.dat = sel ? w[23:20] : w[19:16];
    e.addr = regs[e.ptr] + {20'd0, w[11:0]};
    if (e.ill) begin
      e.addr = '0; e.ptr = '0; e.dat = '0;
    end
    return e;
  endfunction

  task automatic send(input logic [31:0] w, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_insn  = w;
    sb.push_back(model(w, tag));
    #1;
    chk("R10 port A index", {28'd0, rf_raddr_a}, {28'd0, w[23:20]});
    chk("R10 port B index", {28'd0, rf_raddr_b}, {28'd0, w[19:16]});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_insn  = 32'hd7a5_7fff ^ (i * 32'h0101_0101);  // garbage while idle
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] opc, input logic [3:0] ra,
                                     input logic [3:0] rb, input logic sel,
                                     input logic [2:0] rsv, input logic [11:0] disp);
    return {opc, ra, rb, sel, rsv, disp};
  endfunction

  // monitor: compares results away from the clock edge
  initial begin
    logic [31:0] last_addr;
    logic [3:0]  last_ptr, last_dat;
    logic        last_ill;
    exp_t e;
    last_addr = '0; last_ptr = '0; last_dat = '0; last_ill = 1'b0;
    forever begin
      @(posedge clk);
      #5;
      if (rst_n && !done) begin
        if (out_valid) begin
          if (sb.size() == 0) begin
            chk("R2 valid without strobe", {31'd0, out_valid}, 32'd0);
          end else begin
            e = sb.pop_front();
            chk({e.tag, " addr (R7/R5)"}, out_addr, e.addr);
            chk({e.tag, " illegal (R3/R4)"}, {31'd0, out_illegal}, {31'd0, e.ill});
            chk({e.tag, " ptr idx (R6)"}, {28'd0, out_ptr_idx}, {28'd0, e.ptr});
            chk({e.tag, " dat idx (R6)"}, {28'd0, out_dat_idx}, {28'd0, e.dat});
          end
        end else begin
          if (sb.size() != 0)
            chk("R2 missing result", {31'd0, out_valid}, 32'd1);
          chk("R9 hold addr", out_addr, last_addr);
          chk("R9 hold flags", {23'd0, out_ill_dummy(out_illegal), out_ptr_idx, out_dat_idx},
              {23'd0, out_ill_dummy(last_ill), last_ptr, last_dat});
        end
        last_addr = out_addr; last_ptr = out_ptr_idx;
        last_dat  = out_dat_idx; last_ill = out_illegal;
      end
    end
  end

  function automatic logic out_ill_dummy(input logic b);
    return b;
  endfunction

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'h0101_0000 * i + 32'h0000_0330;
    regs[3]  = 32'hFFFF_FFFF;
    regs[14] = 32'hFFFF_F800;
    regs[15] = 32'hFFFF_FF00;

    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {out_valid, out_illegal, out_addr[29:0]}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {out_valid, out_illegal, out_ptr_idx, out_dat_idx, out_addr[21:0]}, 32'd0);
    chk("R1 addr after release", out_addr, 32'd0);

    // basic legal forms, both pointer roles
    send(mk(8'hd0, 4'd1, 4'd2, 1'b0, 3'd0, 12'h010), "R6 first ptr");
    send(mk(8'hd5, 4'd1, 4'd2, 1'b1, 3'd0, 12'h010), "R6 second ptr");
    send(mk(8'hd7, 4'd9, 4'd4, 1'b0, 3'd0, 12'hFFF), "R7 max disp");
    send(mk(8'hd3, 4'd0, 4'd6, 1'b1, 3'd0, 12'h000), "R7 zero disp");
    idle(3);
    // wrap
    send(mk(8'hd1, 4'd3, 4'd5, 1'b0, 3'd0, 12'h001), "R8 wrap by one");
    send(mk(8'hd2, 4'd7, 4'd15, 1'b1, 3'd0, 12'h1FF), "R8 wrap swapped");
    send(mk(8'hd6, 4'd14, 4'd2, 1'b0, 3'd0, 12'h800), "R8 wrap exact zero");
    idle(2);
    // same register in both fields
    send(mk(8'hd4, 4'd8, 4'd8, 1'b0, 3'd0, 12'h123), "R11 same reg sel0");
    send(mk(8'hd4, 4'd8, 4'd8, 1'b1, 3'd0, 12'h123), "R11 same reg sel1");
    // opcode boundaries
    send(mk(8'hcf, 4'd1, 4'd2, 1'b0, 3'd0, 12'h010), "R3 below group");
    send(mk(8'hd8, 4'd1, 4'd2, 1'b1, 3'd0, 12'h010), "R3 above group");
    send(mk(8'h50, 4'd4, 4'd5, 1'b0, 3'd0, 12'h010), "R3 tag bit differs");
    idle(1);
    // reserved bits, one at a time and together
    send(mk(8'hd0, 4'd1, 4'd2, 1'b0, 3'd1, 12'h010), "R4 rsv bit12");
    send(mk(8'hd0, 4'd1, 4'd2, 1'b0, 3'd2, 12'h010), "R4 rsv bit13");
    send(mk(8'hd0, 4'd1, 4'd2, 1'b1, 3'd4, 12'h010), "R4 rsv bit14");
    // both faults together, then legal right after an illegal one
    send(mk(8'hff, 4'd9, 4'd3, 1'b1, 3'd7, 12'hABC), "R5 both faults");
    send(mk(8'hd2, 4'd9, 4'd3, 1'b1, 3'd0, 12'hABC), "R8 after fault");
    idle(4);
    // sweep every opcode in group and every register pair position
    for (int k = 0; k < 32; k++)
      send(mk(8'hd0 + 8'(k % 8), 4'(k), 4'(15 - k), k[0], 3'd0, 12'(k * 97)), "R7 sweep");
    idle(2);
    for (int k = 0; k < 8; k++) begin
      send(mk(8'hc8 + 8'(k * 3), 4'(k), 4'(k + 3), k[1], 3'(k), 12'(k * 5)), "R3 mixed");
      idle(k % 3);
    end
    idle(3);
    chk("R2 all results consumed", sb.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule